// File: doc/BRIEF.md
# Power-Fail Recall and Write Guard

This block sequences the supply events of a nonvolatile SRAM. Three comparator results arrive as digital levels, already synchronous to the block clock: supply below the reset level, supply below the switch level, and backup capacitor below the switch level. The block keeps a pending-recall flag that is raised at power-up and during every brownout. It launches the array recall once the supply is good again and times it with a cycle counter. It also times stores that are either requested from outside or triggered by a falling capacitor voltage.

The block gates the SRAM write strobe. Writes are refused while the supply is low, while a recall is still pending, and during any recall or store. A write that was already being held (chip enable and write enable both low) when a recall or store finished stays blocked until one of those two strobes makes a fresh falling transition. A drop of the capacitor voltage produces a timed pulse that announces an automatic store. A configuration input can suppress automatic stores, so that only explicit requests store.

Top module: `pfg_guard`

## Requirements
- R1: During reset every busy output and `writeEn` are 0. The pending-recall flag resets to set and is set again in every cycle `vccLowReset` is 1. While `vccLowSwitch` is 1, no recall starts.
- R2: With a recall pending and both supply flags at 0, `recallBusy` rises on the next clock edge and stays 1 for exactly RECALL_CYCLES cycles. When it completes, the pending flag clears.
- R3: If `vccLowReset` is 1 during a recall, `recallBusy` drops on the next edge and the recall stays pending. The recall restarts once the supply is good.
- R4: `storeReq` is ignored and `writeEn` stays 0 while `vccLowSwitch` is 1 or a recall is pending.
- R5: `storeReq` sampled at 1 in idle, with good supply and no pending recall, makes `storeBusy` 1 for exactly STORE_CYCLES cycles from the next edge.
- R6: `writeEn` is 1 only in idle, with good supply, no pending recall, `ceN`=0 and `weN`=0, and the write armed. The arm is set by a falling edge of `ceN` or `weN` (the current cycle's edge counts). It is cleared when a recall or store ends.
- R7: A 0-to-1 change of `capLowSwitch` with `autoInhibit`=0 drives `autoPulse` to 1 for PULSE_CYCLES cycles from the next edge. If the block is idle with no pending recall, the same change also starts a store of STORE_CYCLES cycles, even while `vccLowSwitch` is 1.
- R8: With `autoInhibit`=1, a capacitor drop starts neither a pulse nor a store, while `storeReq` still starts a store.
- R9: `recallBusy` and `storeBusy` are never 1 together. `busy` is 1 exactly when either of them or `autoPulse` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| vccLowReset | input | 1 | Supply below reset level |
| vccLowSwitch | input | 1 | Supply below switch level |
| capLowSwitch | input | 1 | Backup capacitor below switch level |
| autoInhibit | input | 1 | Suppress automatic stores |
| storeReq | input | 1 | Explicit store request |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| recallBusy | output | 1 | Recall in progress |
| storeBusy | output | 1 | Store in progress |
| autoPulse | output | 1 | Automatic-store announcement pulse |
| busy | output | 1 | Any operation or pulse active |
| writeEn | output | 1 | Qualified SRAM write strobe |

## Verification
The bench builds the block with RECALL_CYCLES=5, STORE_CYCLES=4 and PULSE_CYCLES=3. These short windows let every duration be counted cycle by cycle. A recall can be aborted and restarted inside a few cycles. Because the pulse is shorter than the store, the cycle in which `busy` is held only by the store, after `autoPulse` has ended, is also visible.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RECALL = 2'd1,
    PH_STORE  = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadRecall;
    logic loadStore;
    logic countDown;
    logic opEnd;
    logic clearPend;
    logic idle;
  } strobe_t;
endpackage

// File: rtl/pfg_datapath.sv
module pfg_datapath
  import pfg_pkg::*;
#(
  parameter int RECALL_CYCLES = 20,
  parameter int STORE_CYCLES  = 12,
  parameter int PULSE_CYCLES  = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic    vccLowReset,
  input  logic    vccLowSwitch,
  input  logic    capLowSwitch,
  input  logic    autoInhibit,
  input  logic    ceN,
  input  logic    weN,
  output logic    pend,
  output logic    cntDone,
  output logic    autoTrig,
  output logic    autoPulse,
  output logic    writeEn
);
  localparam int OP_MAX = (RECALL_CYCLES > STORE_CYCLES) ? RECALL_CYCLES : STORE_CYCLES;
  localparam int CNT_W  = $clog2(OP_MAX + 1);
  localparam int PUL_W  = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RECALL_LOAD = CNT_W'(RECALL_CYCLES - 1);
  localparam logic [CNT_W-1:0] STORE_LOAD  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [PUL_W-1:0] PULSE_LOAD  = PUL_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] opCnt;
  logic [PUL_W-1:0] pulseCnt;
  logic ceNq, weNq, capQ, armed, strobeFall;

  // operation length counter
  always_ff @(posedge clk) begin
    if (!rstN)                          opCnt <= '0;
    else if (strobe.loadRecall)         opCnt <= RECALL_LOAD;
    else if (strobe.loadStore)          opCnt <= STORE_LOAD;
    else if (strobe.countDown && opCnt != '0) opCnt <= opCnt - 1'b1;
  end
  assign cntDone = (opCnt == '0);

  // pending recall: set by reset and by every cycle below the reset level
  always_ff @(posedge clk) begin
    if (!rstN)                  pend <= 1'b1;
    else if (vccLowReset)       pend <= 1'b1;
    else if (strobe.clearPend)  pend <= 1'b0;
  end

  // edge detectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceNq <= 1'b1;
      weNq <= 1'b1;
      capQ <= 1'b1;
    end else begin
      ceNq <= ceN;
      weNq <= weN;
      capQ <= capLowSwitch;
    end
  end
  assign strobeFall = (ceNq & ~ceN) | (weNq & ~weN);
  assign autoTrig   = capLowSwitch & ~capQ & ~autoInhibit;

  // write arm: cleared at the end of each operation, set by a fresh strobe edge
  always_ff @(posedge clk) begin
    if (!rstN)              armed <= 1'b0;
    else if (strobe.opEnd)  armed <= 1'b0;
    else if (strobeFall)    armed <= 1'b1;
  end

  assign writeEn = strobe.idle & ~pend & ~vccLowSwitch & ~ceN & ~weN & (armed | strobeFall);

  // automatic-store announcement pulse
  always_ff @(posedge clk) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (autoTrig)         pulseCnt <= PULSE_LOAD;
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end
  assign autoPulse = (pulseCnt != '0);
endmodule

// File: rtl/pfg_control.sv
module pfg_control
  import pfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pend,
  input  logic    cntDone,
  input  logic    autoTrig,
  input  logic    storeReq,
  input  logic    vccLowReset,
  input  logic    vccLowSwitch,
  output strobe_t strobe,
  output phase_t  phase
);
  phase_t phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: begin
        strobe.idle = 1'b1;
        if (pend && !vccLowSwitch && !vccLowReset) begin
          phaseNext         = PH_RECALL;
          strobe.loadRecall = 1'b1;
        end else if (!pend && autoTrig) begin
          phaseNext        = PH_STORE;
          strobe.loadStore = 1'b1;
        end else if (!pend && storeReq && !vccLowSwitch) begin
          phaseNext        = PH_STORE;
          strobe.loadStore = 1'b1;
        end
      end
      PH_RECALL: begin
        if (vccLowReset) begin
          phaseNext = PH_IDLE;             // abort, request stays latched
        end else if (cntDone) begin
          phaseNext        = PH_IDLE;
          strobe.opEnd     = 1'b1;
          strobe.clearPend = 1'b1;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      PH_STORE: begin
        if (cntDone) begin
          phaseNext    = PH_IDLE;
          strobe.opEnd = 1'b1;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/pfg_guard.sv
module pfg_guard
  import pfg_pkg::*;
#(
  parameter int RECALL_CYCLES = 20,
  parameter int STORE_CYCLES  = 12,
  parameter int PULSE_CYCLES  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccLowReset,
  input  logic vccLowSwitch,
  input  logic capLowSwitch,
  input  logic autoInhibit,
  input  logic storeReq,
  input  logic ceN,
  input  logic weN,
  output logic recallBusy,
  output logic storeBusy,
  output logic autoPulse,
  output logic busy,
  output logic writeEn
);
  strobe_t strobe;
  phase_t  phase;
  logic    pend, cntDone, autoTrig;

  pfg_control i_ctrl (
    .clk(clk), .rstN(rstN), .pend(pend), .cntDone(cntDone), .autoTrig(autoTrig),
    .storeReq(storeReq), .vccLowReset(vccLowReset), .vccLowSwitch(vccLowSwitch),
    .strobe(strobe), .phase(phase)
  );

  pfg_datapath #(
    .RECALL_CYCLES(RECALL_CYCLES), .STORE_CYCLES(STORE_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vccLowReset(vccLowReset),
    .vccLowSwitch(vccLowSwitch), .capLowSwitch(capLowSwitch), .autoInhibit(autoInhibit),
    .ceN(ceN), .weN(weN), .pend(pend), .cntDone(cntDone), .autoTrig(autoTrig),
    .autoPulse(autoPulse), .writeEn(writeEn)
  );

  assign recallBusy = (phase == PH_RECALL);
  assign storeBusy  = (phase == PH_STORE);
  assign busy       = recallBusy | storeBusy | autoPulse;
endmodule

// File: rtl/pfg_guard_checker.sv
module pfg_guard_checker (
  input logic clk,
  input logic rstN,
  input logic vccLowReset,
  input logic vccLowSwitch,
  input logic capLowSwitch,
  input logic autoInhibit,
  input logic ceN,
  input logic weN,
  input logic recallBusy,
  input logic storeBusy,
  input logic autoPulse,
  input logic writeEn
);
  assert_no_write_low_supply_R4: assert property (@(posedge clk) disable iff (!rstN)
    vccLowSwitch |-> !writeEn);

  assert_no_ext_store_low_supply_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(storeBusy) && $past(vccLowSwitch)) |-> autoPulse);

  assert_write_only_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> !(recallBusy || storeBusy));

  assert_rearm_after_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(storeBusy) && $stable(ceN) && $stable(weN)) |-> !writeEn);

  assert_ops_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({recallBusy, storeBusy}));

  assert_recall_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    (recallBusy && vccLowReset) |=> !recallBusy);

  assert_recall_needs_supply_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recallBusy) |-> $past(!vccLowSwitch && !vccLowReset));

  assert_auto_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && capLowSwitch && !$past(capLowSwitch) && !autoInhibit) |=> autoPulse);

  assert_inhibit_no_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(autoInhibit) && !$past(autoPulse)) |-> !autoPulse);
endmodule

bind pfg_guard pfg_guard_checker i_chk (
  .clk(clk), .rstN(rstN), .vccLowReset(vccLowReset), .vccLowSwitch(vccLowSwitch),
  .capLowSwitch(capLowSwitch), .autoInhibit(autoInhibit), .ceN(ceN), .weN(weN),
  .recallBusy(recallBusy), .storeBusy(storeBusy), .autoPulse(autoPulse), .writeEn(writeEn)
);

// File: tb/test_pfg_guard.sv
module test_pfg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 5;
  localparam int SC = 4;
  localparam int PC = 3;

  logic clk = 1'b0;
  logic rstN, vccLowReset, vccLowSwitch, capLowSwitch, autoInhibit, storeReq, ceN, weN;
  logic recallBusy, storeBusy, autoPulse, busy, writeEn;
  int   applied = 0;
  int   miscompares = 0;

  // {vccLowSwitch, ceN, weN, expected writeEn}, walked with the write armed state carried along
  localparam logic [3:0] WR_VEC [7] = '{
    4'b0001, 4'b0010, 4'b1000, 4'b0001, 4'b0100, 4'b0110, 4'b0001
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pfg_guard #(.RECALL_CYCLES(RC), .STORE_CYCLES(SC), .PULSE_CYCLES(PC)) i_pfg_guard (
    .clk(clk), .rstN(rstN), .vccLowReset(vccLowReset), .vccLowSwitch(vccLowSwitch),
    .capLowSwitch(capLowSwitch), .autoInhibit(autoInhibit), .storeReq(storeReq),
    .ceN(ceN), .weN(weN), .recallBusy(recallBusy), .storeBusy(storeBusy),
    .autoPulse(autoPulse), .busy(busy), .writeEn(writeEn)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; vccLowReset = 1'b1; vccLowSwitch = 1'b1; capLowSwitch = 1'b0;
    autoInhibit = 1'b0; storeReq = 1'b0; ceN = 1'b1; weN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset recallBusy", recallBusy, 1'b0);
    chk("R1 reset storeBusy", storeBusy, 1'b0);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset writeEn", writeEn, 1'b0);

    // supply above reset but below switch: nothing may start
    rstN = 1'b1; vccLowReset = 1'b0; storeReq = 1'b1; ceN = 1'b0; weN = 1'b0;
    #1 chk("R4 write under low supply", writeEn, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 no recall under low supply", recallBusy, 1'b0);
      chk("R4 store request ignored", storeBusy, 1'b0);
    end
    storeReq = 1'b0; ceN = 1'b1; weN = 1'b1;

    // supply good: recall starts; write strobes held low across it
    @(negedge clk); vccLowSwitch = 1'b0; ceN = 1'b0; weN = 1'b0;
    for (int i = 0; i < RC; i++) begin
      @(negedge clk);
      chk("R2 recall active", recallBusy, 1'b1);
      chk("R9 busy during recall", busy, 1'b1);
    end
    @(negedge clk);
    chk("R2 recall ended", recallBusy, 1'b0);
    #1 chk("R6 held write blocked after recall", writeEn, 1'b0);
    ceN = 1'b1;
    @(negedge clk); ceN = 1'b0;
    #1 chk("R6 fresh edge arms write", writeEn, 1'b1);
    @(negedge clk); ceN = 1'b1; weN = 1'b1;

    // vector walk of the write gate
    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      vccLowSwitch = WR_VEC[v][3]; ceN = WR_VEC[v][2]; weN = WR_VEC[v][1];
      #1 chk(WR_VEC[v][3] ? "R4 vector write gate" : "R6 vector write gate", writeEn, WR_VEC[v][0]);
    end
    @(negedge clk); vccLowSwitch = 1'b0; ceN = 1'b1; weN = 1'b1;

    // brownout latches a new recall, then abort and restart
    @(negedge clk); vccLowReset = 1'b1; vccLowSwitch = 1'b1;
    @(negedge clk);
    @(negedge clk); vccLowReset = 1'b0; vccLowSwitch = 1'b0;
    @(negedge clk); chk("R1 brownout latched recall", recallBusy, 1'b1);
    @(negedge clk); vccLowReset = 1'b1;
    @(negedge clk); chk("R3 recall aborted", recallBusy, 1'b0);
    vccLowReset = 1'b0;
    @(negedge clk); chk("R3 recall restarted", recallBusy, 1'b1);
    for (int i = 0; i < RC - 1; i++) @(negedge clk);
    chk("R3 restarted recall full length", recallBusy, 1'b1);
    @(negedge clk); chk("R2 restarted recall ended", recallBusy, 1'b0);

    // explicit store
    storeReq = 1'b1;
    @(negedge clk); storeReq = 1'b0;
    chk("R5 store started", storeBusy, 1'b1);
    for (int i = 0; i < SC - 1; i++) begin
      @(negedge clk); chk("R5 store active", storeBusy, 1'b1);
    end
    @(negedge clk); chk("R5 store ended", storeBusy, 1'b0);

    // automatic store during low supply
    vccLowSwitch = 1'b1; capLowSwitch = 1'b1;
    for (int c = 1; c <= SC + 1; c++) begin
      @(negedge clk);
      chk("R7 auto pulse", autoPulse, (c <= PC));
      chk("R7 auto store", storeBusy, (c <= SC));
      chk("R9 busy covers pulse or store", busy, (c <= SC));
    end
    capLowSwitch = 1'b0; vccLowSwitch = 1'b0;
    @(negedge clk);

    // inhibit mode
    autoInhibit = 1'b1;
    @(negedge clk); capLowSwitch = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8 no pulse when inhibited", autoPulse, 1'b0);
      chk("R8 no auto store when inhibited", storeBusy, 1'b0);
    end
    storeReq = 1'b1;
    @(negedge clk); storeReq = 1'b0;
    chk("R8 explicit store still allowed", storeBusy, 1'b1);
    repeat (SC) @(negedge clk);
    chk("R5 inhibited-mode store ended", storeBusy, 1'b0);

    // explicit store under low supply is refused
    vccLowSwitch = 1'b1; storeReq = 1'b1;
    repeat (2) begin
      @(negedge clk); chk("R4 store refused low supply", storeBusy, 1'b0);
    end
    storeReq = 1'b0;

    summary();
    $finish;
  end
endmodule